// File: doc/BRIEF.md
# Interrupt Moderation Throttle Unit

This block gathers interrupt cause bits from the rest of a device and decides when to raise an interrupt toward the host. The aim is to keep host interrupts at least a programmable minimum distance apart. Every posted cause is merged into a sticky cause register, whether or not an interrupt follows. A host read-clear strobe empties that register.

The minimum distance is set by an interval register counted in units of 256 timebase ticks. A free-running 64-bit timebase is an input to the block. The time at which an interrupt is actually delivered is recorded. A later post fires at once if the interval is zero, if the post is forced, if no interrupt has been delivered since reset, or if enough time has passed since the last delivery. Otherwise one deferred timer is armed. It fires when the spacing has elapsed, and any posts that arrive while it waits only add their cause bits.

Top module: `intr_throttle`

## Requirements
- R1: Each post ORs `post_cause` into `cause_q`, one cycle after the post. Bits already set stay set until a clear.
- R2: `rd_clear` zeroes `cause_q` one cycle later. If a post arrives in the same cycle as the clear, its bits are set afterwards.
- R3: When `ivl_units` is zero, a post produces `irq_pulse` high in the next cycle.
- R4: A post with `post_force` high produces `irq_pulse` in the next cycle, whatever the interval.
- R5: A post is delivered immediately when last_delivery + `ivl_units`*256 <= `now`. This includes the equality case.
- R6: A post made before the spacing has elapsed gives no pulse then. It arms a timer, and the pulse appears one cycle after the first cycle in which `now` equals or exceeds last_delivery + `ivl_units`*256.
- R7: While the timer is armed, further throttled posts only accumulate cause bits and add no pulse.
- R8: An immediate post made while the timer is armed cancels the timer, so that only one pulse results.
- R9: The delivery time recorded is the `now` value of the cycle in which the interrupt is decided. Deferred deadlines are measured from it.
- R10: The first post after reset is delivered immediately. `cause_q` and `irq_pulse` are zero out of reset.
- R11: The deadline sum is formed one bit wider than the timebase. A last delivery time near the top of the 64-bit range therefore never looks as if the spacing has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Cause vector is being posted this cycle |
| post_cause | input | CAUSE_W | Cause bits to merge |
| post_force | input | 1 | Deliver this post without throttling |
| ivl_units | input | IVL_W | Minimum spacing in 256-tick units |
| now | input | TIME_W | Free-running timebase |
| rd_clear | input | 1 | Host read-clear of the cause register |
| cause_q | output | CAUSE_W | Accumulated cause register |
| irq_pulse | output | 1 | Interrupt request, high one cycle per delivery |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the cause register keeps each posted bit and empties after a lone clear;
- forced posts, zero-interval posts and the first post after reset always pulse in the next cycle;
- each pulse records the timebase value of its decision cycle;
- an armed timer swallows posts that are still being throttled.

Other behaviours only the bench scenarios can show, because each needs a walk through time:
- that the deferred pulse lands on exactly the deadline cycle;
- the equality boundary of the spacing check;
- that a forced post really removes the pending timer pulse;
- that the deadline does not wrap near the top of the timebase.

// File: rtl/ithr_pkg.sv
package ithr_pkg;

    // Why an interrupt is raised in a given cycle.
    typedef enum logic [1:0] {
        FIRE_NONE  = 2'd0,
        FIRE_NOW   = 2'd1,
        FIRE_TIMER = 2'd2
    } ithr_fire_e;

endpackage

// File: rtl/ithr_cause_acc.sv
module ithr_cause_acc #(
    parameter int CAUSE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_valid,
    input  logic [CAUSE_W-1:0] post_cause,
    input  logic               rd_clear,
    output logic [CAUSE_W-1:0] cause_q
);

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        logic [CAUSE_W-1:0] kept;
        logic [CAUSE_W-1:0] added;
        acc_d = acc_q;
        kept  = rd_clear ? '0 : acc_q.cause;
        added = post_valid ? post_cause : '0;
        // A post in the clear cycle lands after the clear.
        acc_d.cause = kept | added;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign cause_q = acc_q.cause;

    // R1: posted bits are present in the next cycle.
    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> ((cause_q & $past(post_cause)) == $past(post_cause)));

    // R2: a clear with no post leaves the register empty.
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !post_valid) |=> (cause_q == '0));

endmodule

// File: rtl/ithr_due_calc.sv
module ithr_due_calc #(
    parameter int TIME_W     = 64,
    parameter int IVL_W      = 16,
    parameter int UNIT_SHIFT = 8
) (
    input  logic [TIME_W-1:0] last_ts,
    input  logic [IVL_W-1:0]  ivl_units,
    input  logic [TIME_W-1:0] now,
    output logic              due
);

    localparam int SUM_W = TIME_W + 1;

    logic [SUM_W-1:0] span;
    logic [SUM_W-1:0] deadline;

    always_comb begin
        span     = SUM_W'(ivl_units) << UNIT_SHIFT;
        deadline = {1'b0, last_ts} + span;
        due      = (deadline <= {1'b0, now});
    end

    initial begin
        p_span_fits_r11: assert (IVL_W + UNIT_SHIFT < SUM_W);
    end

endmodule

// File: rtl/ithr_ctrl.sv
module ithr_ctrl
    import ithr_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int IVL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_valid,
    input  logic              post_force,
    input  logic [IVL_W-1:0]  ivl_units,
    input  logic [TIME_W-1:0] now,
    input  logic              due,
    output logic [TIME_W-1:0] last_ts,
    output logic              irq_pulse
);

    typedef struct packed {
        logic              armed;
        logic              hist;
        logic [TIME_W-1:0] last;
        logic              pulse;
    } ctrl_t;

    ctrl_t      st_d, st_q;
    ithr_fire_e reason;

    always_comb begin
        logic zero_ivl;
        logic imm;
        logic tmr;
        zero_ivl = (ivl_units == '0);
        imm      = post_valid && (post_force || zero_ivl || !st_q.hist || due);
        tmr      = st_q.armed && due;
        if (imm)      reason = FIRE_NOW;
        else if (tmr) reason = FIRE_TIMER;
        else          reason = FIRE_NONE;

        st_d       = st_q;
        st_d.pulse = (reason != FIRE_NONE);
        if (reason != FIRE_NONE) begin
            st_d.last  = now;
            st_d.hist  = 1'b1;
            st_d.armed = 1'b0;
        end else if (post_valid) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_ts   = st_q.last;
    assign irq_pulse = st_q.pulse;

    // R3: zero interval bypasses throttling.
    p_zero_ivl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && ivl_units == '0) |=> irq_pulse);

    // R4: force bypasses throttling.
    p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && post_force) |=> irq_pulse);

    // R9: every pulse carries the timebase of its decision cycle.
    p_stamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (last_ts == $past(now)));

    // R7: a throttled post while armed adds no pulse.
    p_armed_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && post_valid && !post_force && ivl_units != '0 && !due)
        |=> !irq_pulse);

    // R10: first post after reset is delivered at once.
    p_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && !st_q.hist) |=> irq_pulse);

endmodule

// File: rtl/intr_throttle.sv
module intr_throttle #(
    parameter int CAUSE_W    = 8,
    parameter int IVL_W      = 16,
    parameter int TIME_W     = 64,
    parameter int UNIT_SHIFT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_valid,
    input  logic [CAUSE_W-1:0] post_cause,
    input  logic               post_force,
    input  logic [IVL_W-1:0]   ivl_units,
    input  logic [TIME_W-1:0]  now,
    input  logic               rd_clear,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               irq_pulse
);

    logic [TIME_W-1:0] last_ts;
    logic              due;

    ithr_cause_acc #(.CAUSE_W(CAUSE_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_valid (post_valid),
        .post_cause (post_cause),
        .rd_clear   (rd_clear),
        .cause_q    (cause_q)
    );

    ithr_due_calc #(
        .TIME_W     (TIME_W),
        .IVL_W      (IVL_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) u_due (
        .last_ts   (last_ts),
        .ivl_units (ivl_units),
        .now       (now),
        .due       (due)
    );

    ithr_ctrl #(
        .TIME_W (TIME_W),
        .IVL_W  (IVL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_valid (post_valid),
        .post_force (post_force),
        .ivl_units  (ivl_units),
        .now        (now),
        .due        (due),
        .last_ts    (last_ts),
        .irq_pulse  (irq_pulse)
    );

endmodule

// File: tb/intr_throttle_test.sv
module intr_throttle_test;

    localparam int CW = 8;
    localparam int IW = 16;
    localparam int TW = 64;
    localparam longint unsigned SPAN1 = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          post_valid = 1'b0;
    logic [CW-1:0] post_cause = '0;
    logic          post_force = 1'b0;
    logic [IW-1:0] ivl_units = '0;
    logic [TW-1:0] tnow = 64'd1000;
    logic          rd_clear = 1'b0;
    logic [CW-1:0] cause_q;
    logic          irq_pulse;

    int n_chk = 0;
    int n_fail = 0;
    logic [TW-1:0] last_fire;

    always #5 clk = ~clk;

    intr_throttle uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_valid (post_valid),
        .post_cause (post_cause),
        .post_force (post_force),
        .ivl_units  (ivl_units),
        .now        (tnow),
        .rd_clear   (rd_clear),
        .cause_q    (cause_q),
        .irq_pulse  (irq_pulse)
    );

    typedef struct packed {
        logic          pv;
        logic [CW-1:0] cause;
        logic          force_i;
        logic          clr;
        logic [IW-1:0] ivl;
        logic          exp_pulse;
        logic [CW-1:0] exp_cause;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 8'h01, 1'b0, 1'b0, 16'd0, 1'b1, 8'h01}, // R10 R3
        '{1'b1, 8'h04, 1'b0, 1'b0, 16'd0, 1'b1, 8'h05}, // R1 R3
        '{1'b0, 8'h00, 1'b0, 1'b1, 16'd0, 1'b0, 8'h00}, // R2
        '{1'b1, 8'h80, 1'b0, 1'b1, 16'd0, 1'b1, 8'h80}, // R2 post wins
        '{1'b1, 8'h02, 1'b0, 1'b0, 16'd0, 1'b1, 8'h82}, // R1
        '{1'b0, 8'h00, 1'b0, 1'b0, 16'd0, 1'b0, 8'h82}, // R1 hold
        '{1'b1, 8'h10, 1'b1, 1'b0, 16'd5, 1'b1, 8'h92}, // R4
        '{1'b0, 8'h00, 1'b0, 1'b1, 16'd5, 1'b0, 8'h00}  // R2
    };

    task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at now=%0h", req, act, exp, tnow);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        post_valid = 1'b0;
        post_cause = '0;
        post_force = 1'b0;
        rd_clear   = 1'b0;
    endtask

    // One cycle; the pulse is expected iff this cycle's now equals dl.
    task automatic step_expect(input string req, input logic [TW-1:0] dl);
        cyc();
        check(req, {63'd0, irq_pulse}, {63'd0, tnow == dl});
        if (irq_pulse) last_fire = tnow;
        idle_inputs();
        tnow = tnow + 1;
    endtask

    task automatic post(input logic [CW-1:0] c, input logic f);
        post_valid = 1'b1;
        post_cause = c;
        post_force = f;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [TW-1:0] dl;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        check("R10 reset cause", {56'd0, cause_q}, 64'd0);
        check("R10 reset pulse", {63'd0, irq_pulse}, 64'd0);

        // Vector table: untimed paths (zero interval, force, clear).
        for (int i = 0; i < 8; i++) begin
            post_valid = VEC[i].pv;
            post_cause = VEC[i].cause;
            post_force = VEC[i].force_i;
            rd_clear   = VEC[i].clr;
            ivl_units  = VEC[i].ivl;
            cyc();
            check($sformatf("R1/R2/R3/R4 vec%0d pulse", i), {63'd0, irq_pulse}, {63'd0, VEC[i].exp_pulse});
            check($sformatf("R1/R2 vec%0d cause", i), {56'd0, cause_q}, {56'd0, VEC[i].exp_cause});
            if (VEC[i].exp_pulse) last_fire = tnow;
            idle_inputs();
            tnow = tnow + 1;
        end

        // R6 R7 R9: deferred fire measured from the last delivery.
        ivl_units = 16'd1;
        dl = last_fire + SPAN1;
        post(8'h08, 1'b0);
        step_expect("R6 deferred post", dl);
        check("R1 deferred cause", {56'd0, cause_q}, 64'h08);
        while (tnow < last_fire + 100) step_expect("R6 wait", dl);
        post(8'h20, 1'b0);
        step_expect("R7 armed post", dl);
        check("R7 armed accumulate", {56'd0, cause_q}, 64'h28);
        while (tnow <= dl) step_expect("R6 R9 timer fire", dl);

        // R5: equality boundary fires immediately.
        dl = last_fire + SPAN1;
        while (tnow < dl) step_expect("R5 idle", 64'hFFFF_FFFF_FFFF_FFFF);
        post(8'h01, 1'b0);
        step_expect("R5 equal boundary", dl);

        // R5/R6: one tick short defers to the next cycle.
        dl = last_fire + SPAN1;
        while (tnow < dl - 1) step_expect("R5 idle2", 64'hFFFF_FFFF_FFFF_FFFF);
        post(8'h02, 1'b0);
        step_expect("R5 one short", dl);
        step_expect("R6 next cycle fire", dl);

        // R8: force while armed cancels the timer.
        dl = last_fire + 10;
        while (tnow < dl) step_expect("R8 idle", 64'hFFFF_FFFF_FFFF_FFFF);
        post(8'h04, 1'b0);
        step_expect("R8 arm", 64'hFFFF_FFFF_FFFF_FFFF);
        dl = tnow + 9;
        while (tnow < dl) step_expect("R8 idle2", 64'hFFFF_FFFF_FFFF_FFFF);
        post(8'h40, 1'b1);
        step_expect("R8 force", dl);
        dl = last_fire + SPAN1 + 20;
        while (tnow < dl) step_expect("R8 no second pulse", 64'hFFFF_FFFF_FFFF_FFFF);

        // R11: deadline near the top of the timebase must not wrap.
        rd_clear = 1'b1;
        cyc();
        idle_inputs();
        tnow = 64'hFFFF_FFFF_FFFF_FED4;
        ivl_units = 16'd0;
        post(8'h01, 1'b0);
        step_expect("R3 high time", 64'hFFFF_FFFF_FFFF_FED4);
        ivl_units = 16'hFFFF;
        repeat (10) step_expect("R11 idle", 64'd0);
        post(8'h02, 1'b0);
        step_expect("R11 no wrap", 64'd0);
        repeat (5) step_expect("R11 still held", 64'd0);
        check("R11 cause", {56'd0, cause_q}, 64'h03);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule